// File: doc/BRIEF.md
# 32-bit Multi-Operation ALU with Set-Compare

This block computes one of twelve data operations on two 32-bit operands, or answers one of ten comparisons between them as a whole-word 0 or 1. Arithmetic, bitwise logic, three shift kinds, passing either operand through, and the constants 0 and 1 all share one 5-bit operation code. Every comparison is derived from the same adder that subtracts. It reuses the overflow and borrow of that subtraction, so no separate comparator is needed.

The datapath is combinational. A parameter selects whether the result is captured in an output register, which gives one cycle of latency and a synchronous active-low clear. Operand 2 supplies the shift distance. Only its low five bits are used. Bit 31 is the most significant bit throughout.

Top module: `alu_core`

## Requirements
- R1: Code 0 yields a+b and code 1 yields a-b, both wrapping modulo 2^32 with no other indication.
- R2: Code 2 yields a AND b, code 3 yields a OR b, code 4 yields a XOR b.
- R3: Code 5 shifts a left and code 6 shifts a right logically, in both cases by b[4:0] places with zeros entering; bits b[31:5] have no effect.
- R4: Code 7 shifts a right by b[4:0] places, filling the vacated upper bits with copies of a[31].
- R5: Code 8 yields a unchanged and code 9 yields b unchanged.
- R6: Code 10 yields 0 and code 11 yields 1.
- R7: Codes 16 to 25 yield 1 when their relation holds and 0 otherwise, with bits 31:1 always 0. The relations are: 16 equal, 17 not equal, 18 signed less, 19 signed greater, 20 signed less-or-equal, 21 signed greater-or-equal.
- R8: The signed relations (codes 18 to 21) give the true two's-complement ordering even when a-b overflows, for example a=0x80000000 against b=1.
- R9: Codes 22 to 25 compare unsigned: 22 less, 23 greater, 24 less-or-equal, 25 greater-or-equal.
- R10: Codes 12 to 15 and 26 to 31 yield 0.
- R11: With the output register enabled (the default), y_o shows the result for the inputs present at the previous rising clock edge. While rst_n is low at a rising edge, y_o is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low clear of the output register |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | Operand 1, which is also the value being shifted |
| b_i | input | 32 | Operand 2, which also gives the shift distance in its low bits |
| y_o | output | 32 | Result |

## Verification
A signed comparison and a wrapping subtraction occur together whenever the operands have opposite signs and the difference leaves the 32-bit range. Because the relation is read from that same difference, the two cases cannot be tested apart. The sweep drives every operation code over corner operands such as 0x80000000, 0x7FFFFFFF, 0x80000001 and all-ones in every pairing. Each result is judged against a bench model that uses native signed and unsigned comparison and never looks at a difference. A second pairing is a shift distance in b whose upper bits are set, combined with an arithmetic fill. All 64 values of b[5:0] are applied to negative and positive operands, and the results are checked against the native shift operators.

// File: rtl/alu_pkg.sv
// Package: operation codes and helpers shared by the ALU and its checker.
// Assumes a 5-bit operation code; codes not listed here produce zero.
package alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_SHL   = 5'd5,
        OP_SHR   = 5'd6,
        OP_SHRA  = 5'd7,
        OP_PASSA = 5'd8,
        OP_PASSB = 5'd9,
        OP_ZERO  = 5'd10,
        OP_ONE   = 5'd11,
        OP_CEQ   = 5'd16,
        OP_CNE   = 5'd17,
        OP_CLT   = 5'd18,
        OP_CGT   = 5'd19,
        OP_CLE   = 5'd20,
        OP_CGE   = 5'd21,
        OP_CLTU  = 5'd22,
        OP_CGTU  = 5'd23,
        OP_CLEU  = 5'd24,
        OP_CGEU  = 5'd25
    } alu_op_e;

    // True for the ten compare codes
    function automatic logic is_cmp(input logic [OP_W-1:0] op);
        return (op >= 5'd16) && (op <= 5'd25);
    endfunction

    // True for codes that have no assigned operation
    function automatic logic is_unused(input logic [OP_W-1:0] op);
        return ((op >= 5'd12) && (op <= 5'd15)) || (op >= 5'd26);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder for add, subtract and every comparison.
// Assumes sub_i=1 forms a + ~b + 1. carry_o=1 then means a >= b unsigned,
// and ovf_o flags a signed overflow of the sum or difference.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // Invert operand 2 for subtraction
    assign b_eff = b_i ^ {WIDTH{sub_i}};

    // Single carry chain with the subtract control as carry-in
    assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};

    // Signed overflow: equal input signs but a different result sign
    assign ovf_o = ~(a_i[MSB] ^ b_eff[MSB]) & (a_i[MSB] ^ sum_o[MSB]);

endmodule

// File: rtl/alu_shift.sv
// Module: log-depth barrel shifter covering left, logical right and
// arithmetic right. A left shift is done by mirroring the word, shifting
// right and mirroring back. Assumes WIDTH is a power of two.
module alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0]         mir_in;
    logic [WIDTH-1:0]         mir_out;
    logic [SHW:0][WIDTH-1:0]  stg;
    logic                     fill;

    // Fill bit is the sign only for an arithmetic right shift
    assign fill = arith_i & ~left_i & val_i[WIDTH-1];

    // Mirror the input and the output words (used for left shifts)
    for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
        assign mir_in[i]  = val_i[WIDTH-1-i];
        assign mir_out[i] = stg[SHW][WIDTH-1-i];
    end

    // Stage 0 is the word to be shifted right
    assign stg[0] = left_i ? mir_in : val_i;

    // Stage s moves the word right by 2^s places when amount bit s is set
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][WIDTH-1:D]} : stg[s];
    end

    // Mirror back for left shifts
    assign res_o = left_i ? mir_out : stg[SHW];

endmodule

// File: rtl/alu_setcmp.sv
// Module: turns the flags of a - b into the answer for one compare code.
// Assumes the adder was given sub=1. Signed order uses sign XOR overflow,
// and unsigned order uses the carry-out.
module alu_setcmp #(
    parameter int WIDTH = 32
) (
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] diff_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    output logic             hit_o
);
    import alu_pkg::*;

    logic eq, lt_s, lt_u;

    // Basic relations taken from the difference
    assign eq   = (diff_i == '0);
    assign lt_s = diff_i[WIDTH-1] ^ ovf_i;
    assign lt_u = ~carry_i;

    // Select the relation named by the code
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_CEQ:  hit_o = eq;
            OP_CNE:  hit_o = ~eq;
            OP_CLT:  hit_o = lt_s;
            OP_CGT:  hit_o = ~lt_s & ~eq;
            OP_CLE:  hit_o = lt_s | eq;
            OP_CGE:  hit_o = ~lt_s;
            OP_CLTU: hit_o = lt_u;
            OP_CGTU: hit_o = ~lt_u & ~eq;
            OP_CLEU: hit_o = lt_u | eq;
            OP_CGEU: hit_o = ~lt_u;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
// Module: top of the ALU. Decodes the operation code, steers the shared
// adder, shifter and compare units, and optionally registers the result.
// Assumes WIDTH is a power of two; REG_OUT=1 adds one cycle of latency with
// a synchronous active-low clear.
module alu_core #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    import alu_pkg::*;

    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op;
    logic             sub;
    logic [WIDTH-1:0] sum;
    logic             carry, ovf;
    logic [WIDTH-1:0] shifted;
    logic             sh_left, sh_arith;
    logic             cmp_hit;
    logic [WIDTH-1:0] res;

    // Interpret the raw code
    assign op = alu_op_e'(op_i);

    // The adder subtracts for everything except the add code
    assign sub      = (op != OP_ADD);
    assign sh_left  = (op == OP_SHL);
    assign sh_arith = (op == OP_SHRA);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (sub),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .val_i   (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .res_o   (shifted)
    );

    alu_setcmp #(.WIDTH(WIDTH)) u_setcmp (
        .op_i    (op_i),
        .diff_i  (sum),
        .carry_i (carry),
        .ovf_i   (ovf),
        .hit_o   (cmp_hit)
    );

    // Result select by operation
    always_comb begin
        if (is_cmp(op_i)) begin
            res = {{(WIDTH-1){1'b0}}, cmp_hit};
        end else begin
            unique case (op)
                OP_ADD, OP_SUB:          res = sum;
                OP_AND:                  res = a_i & b_i;
                OP_OR:                   res = a_i | b_i;
                OP_XOR:                  res = a_i ^ b_i;
                OP_SHL, OP_SHR, OP_SHRA: res = shifted;
                OP_PASSA:                res = a_i;
                OP_PASSB:                res = b_i;
                OP_ONE:                  res = {{(WIDTH-1){1'b0}}, 1'b1};
                default:                 res = '0;
            endcase
        end
    end

    // Output stage: a register or a straight wire, chosen by parameter
    if (REG_OUT) begin : g_reg
        // Capture the result on each edge; cleared while reset is low
        always_ff @(posedge clk) begin
            if (!rst_n) y_o <= '0;
            else        y_o <= res;
        end
    end else begin : g_comb
        assign y_o = res;
    end

endmodule

// File: rtl/alu_core_chk.sv
// Module: assertion checker for alu_core, attached with bind. Re-times the
// inputs to line up with y_o, then checks the result for selected codes.
module alu_core_chk #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] y_o
);
    import alu_pkg::*;

    logic [4:0]       op_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic             rst_q;
    logic             vld;

    // Remember the reset level of the previous edge
    always_ff @(posedge clk) rst_q <= rst_n;

    if (REG_OUT) begin : g_reg
        // Delay the inputs by one edge to match the output register
        always_ff @(posedge clk) begin
            op_q <= op_i;
            a_q  <= a_i;
            b_q  <= b_i;
        end
        assign vld = (rst_q === 1'b1);

        AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_q === 1'b0) |-> (y_o == '0)); // R11
    end else begin : g_comb
        assign op_q = op_i;
        assign a_q  = a_i;
        assign b_q  = b_i;
        assign vld  = 1'b1;
    end

    AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && is_cmp(op_q)) |-> (y_o[WIDTH-1:1] == '0)); // R7

    AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_q == OP_CLT) |-> (y_o[0] == ($signed(a_q) < $signed(b_q)))); // R8

    AST_UNSIGNED_GE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_q == OP_CGEU) |-> (y_o[0] == (a_q >= b_q))); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && is_unused(op_q)) |-> (y_o == '0)); // R10

    AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_q == OP_ONE) |-> (y_o == 1)); // R6

    AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_q == OP_PASSB) |-> (y_o == b_q)); // R5

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (y_o)
);

// File: tb/alu_core_bench.sv
// Bench: drives every code over corner operands plus a full sweep of shift
// distances, and checks each result against native-operator arithmetic.
module alu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] y;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] VALS [12] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7FFF_FFFF,
        32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678,
        32'hFFFF_0000, 32'h0000_FFFF, 32'hDEAD_BEEF, 32'h5A5A_5A5A
    };

    always #4 clk = ~clk;

    alu_core #(.WIDTH(32), .REG_OUT(1'b1)) u_alu_core (
        .clk (clk), .rst_n (rst_n), .op_i (op), .a_i (a), .b_i (b), .y_o (y)
    );

    // Bench model of every code, built from native operators
    function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x,
                                          input logic [31:0] z);
        case (o)
            5'd0:  return x + z;
            5'd1:  return x - z;
            5'd2:  return x & z;
            5'd3:  return x | z;
            5'd4:  return x ^ z;
            5'd5:  return x << z[4:0];
            5'd6:  return x >> z[4:0];
            5'd7:  return 32'($signed(x) >>> z[4:0]);
            5'd8:  return x;
            5'd9:  return z;
            5'd10: return 32'd0;
            5'd11: return 32'd1;
            5'd16: return {31'd0, x == z};
            5'd17: return {31'd0, x != z};
            5'd18: return {31'd0, $signed(x) <  $signed(z)};
            5'd19: return {31'd0, $signed(x) >  $signed(z)};
            5'd20: return {31'd0, $signed(x) <= $signed(z)};
            5'd21: return {31'd0, $signed(x) >= $signed(z)};
            5'd22: return {31'd0, x <  z};
            5'd23: return {31'd0, x >  z};
            5'd24: return {31'd0, x <= z};
            5'd25: return {31'd0, x >= z};
            default: return 32'd0;
        endcase
    endfunction

    // Requirement tag for each code
    function automatic string req_of(input logic [4:0] o);
        if (o <= 5'd1)                     return "R1";
        if (o <= 5'd4)                     return "R2";
        if (o <= 5'd6)                     return "R3";
        if (o == 5'd7)                     return "R4";
        if (o <= 5'd9)                     return "R5";
        if (o <= 5'd11)                    return "R6";
        if (o >= 5'd18 && o <= 5'd21)      return "R8";
        if (o >= 5'd22 && o <= 5'd25)      return "R9";
        if (o >= 5'd16 && o <= 5'd17)      return "R7";
        return "R10";
    endfunction

    // Compare one observed value with its expected value
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
        end
    endtask

    // Drive at the falling edge; the registered result is valid just after the next rising edge
    task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] z);
        @(negedge clk);
        op = o; a = x; b = z;
        @(posedge clk);
        #1;
        check(req_of(o), y, model(o, x, z));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11: clear during reset even while a nonzero code is presented
        op = 5'd11; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R11", y, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11", y, 32'd1);

        // R11: one cycle of latency; a new input does not show before the edge
        @(negedge clk);
        op = 5'd9; b = 32'hCAFE_0001;
        #2;
        check("R11", y, 32'd1);
        @(posedge clk);
        #1;
        check("R11", y, 32'hCAFE_0001);

        // All codes over every corner-operand pairing (R1..R10, R8 overflow cases)
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply(5'(o), VALS[i], VALS[j]);

        // R3 and R4: every shift distance, with the upper bits of b set half the time
        for (int s = 5; s <= 7; s++)
            for (int d = 0; d < 64; d++) begin
                apply(5'(s), 32'h8765_4321, {26'h3FF_FFFF * 26'(d >> 5), 6'(d)});
                apply(5'(s), 32'h4000_0001, 32'(d));
            end

        // R8: signed order where a-b overflows
        apply(5'd18, 32'h8000_0000, 32'h0000_0001);
        check("R8", y, 32'd1);
        apply(5'd19, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check("R8", y, 32'd1);

        // R11: a synchronous reset in mid-run clears the register
        @(negedge clk);
        rst_n = 1'b0; op = 5'd8; a = 32'h1111_2222;
        @(posedge clk);
        #1;
        check("R11", y, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11", y, 32'h1111_2222);

        finish_run();
    end

endmodule